// File: doc/BRIEF.md
# Static Memory Bus Turnaround Scheduler

This block sits ahead of a four-bank static-memory controller and decides how many idle cycles must pass between the transfer just granted and the next one waiting. Each request names a bank and carries three flags: direction, synchronous or asynchronous, and multiplexed address/data bus. The scheduler keeps a snapshot of the last granted transfer and counts the cycles since that grant. It compares the snapshot with the waiting request to pick the required gap. It raises `req_ready` once enough cycles have passed.

The gap is not always the programmed one. Writes that were synchronous impose fixed short (2) or long (3) gaps, depending on what follows. Reads impose no gap. An asynchronous write imposes its bank's programmed turnaround count, which can be 0 to 15 cycles. The exception is a following asynchronous write to the same bank, which proceeds at once unless that bank runs a multiplexed bus or access mode D. Each bank has a config slot holding a 4-bit turnaround count and a 2-bit access mode. The mode only counts when the bank's extended-mode enable is high.

Top module: `turnaround_sched`

## Requirements
- R1: After reset no previous transfer is recorded: `req_ready` is high and the first request is granted in the cycle it is presented (zero idle cycles).
- R2: After reset every bank holds turnaround 15 and access mode A (code 00); the config write port (`cfg_we`, `cfg_bank`, `cfg_turn`, `cfg_mode` with A=00, B=01, C=10, D=11) replaces one bank's pair on a clock edge.
- R3: When the previous transfer was an asynchronous write (`req_write`=1, `req_sync`=0), the gap equals that bank's turnaround count as it stood when that write was granted, for every case that R4 does not cover.
- R4: An asynchronous write followed by an asynchronous write to the same bank has a gap of 0. This does not apply when the earlier write had `req_mux`=1 or its bank is in effective mode D; then R3 applies.
- R5: A synchronous write followed by a synchronous write to the same bank has a fixed gap of 2, whatever the programmed count.
- R6: When the previous transfer was a read (`req_write`=0), the gap is 0.
- R7: A synchronous write followed by any asynchronous transfer (read or write, any bank) has a fixed gap of 2.
- R8: A synchronous write followed by a synchronous write to a different bank has a fixed gap of 3.
- R9: A synchronous write followed by a synchronous read (any bank) has a fixed gap of 3.
- R10: A request held valid from the cycle after a grant is granted exactly gap+1 cycles after that grant; `req_ready` stays low until then, and the idle count restarts at each grant.
- R11: A config write made while a gap is being counted does not change that gap; it applies to gaps from writes granted afterwards.
- R12: With a bank's `ext_mode_en` bit low its mode field is ignored and the bank behaves as mode A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_bank | input | 2 | Bank whose config is written |
| cfg_turn | input | 4 | New turnaround count |
| cfg_mode | input | 2 | New access mode code (A=00 .. D=11) |
| ext_mode_en | input | 4 | Per-bank extended-mode enable, bit n for bank n |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be granted this cycle |
| req_bank | input | 2 | Target bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous, 0 = asynchronous |
| req_mux | input | 1 | 1 = multiplexed address/data bus |

## Verification
The bench builds the block with its default parameters: four banks, a 4-bit turnaround field, and fixed gaps of 2 and 3. With these values the 15-cycle reset turnaround can be reached within a short run. A 5-bit idle counter that saturates covers the longest gap. The bench programs banks with distinct counts (6, 4, 5), so a gap taken from the wrong bank shows up as a wrong number. One bank holds mode D with its enable low, which exercises the mode gate. A config write lands in the middle of a 6-cycle gap to confirm that the programmed count was latched when the earlier write was granted.

// File: rtl/tat_pkg.sv
package tat_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int TURN_W    = 4;
    localparam int CNT_W     = TURN_W + 1;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [TURN_W-1:0] turn_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        MODE_A = 2'b00,
        MODE_B = 2'b01,
        MODE_C = 2'b10,
        MODE_D = 2'b11
    } amode_e;

    localparam turn_t  RST_TURN = '1;
    localparam amode_e RST_MODE = MODE_A;

    typedef struct packed {
        turn_t  turn;
        amode_e mode;
    } bank_cfg_t;

    typedef struct packed {
        bank_t bank;
        logic  wr;
        logic  sy;
        logic  mx;
    } xfer_t;

    typedef struct packed {
        logic  vld;
        xfer_t x;
        logic  mode_d;
        turn_t turn;
    } prev_t;

    function automatic cnt_t pick_gap(prev_t p, xfer_t n, cnt_t short_g, cnt_t long_g);
        cnt_t g;
        if (!p.vld || !p.x.wr) begin
            g = '0;
        end else if (p.x.sy) begin
            if (!n.sy)                 g = short_g;
            else if (!n.wr)            g = long_g;
            else if (n.bank == p.x.bank) g = short_g;
            else                       g = long_g;
        end else begin
            if (n.wr && !n.sy && (n.bank == p.x.bank) && !p.x.mx && !p.mode_d)
                g = '0;
            else
                g = cnt_t'(p.turn);
        end
        return g;
    endfunction
endpackage

// File: rtl/tat_cfg_regs.sv
module tat_cfg_regs
    import tat_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  bank_t                       wbank,
    input  bank_cfg_t                   wcfg,
    output bank_cfg_t [NUM_BANKS-1:0]   cfg_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[b].turn <= RST_TURN;
                cfg_q[b].mode <= RST_MODE;
            end else if (we && (wbank == bank_t'(b))) begin
                cfg_q[b] <= wcfg;
            end
        end

        // R2: reset contents
        a_r2_cfg_reset: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (cfg_q[b].turn == RST_TURN && cfg_q[b].mode == RST_MODE));
    end
endmodule

// File: rtl/tat_gap_sel.sv
module tat_gap_sel
    import tat_pkg::*;
#(
    parameter int SHORT_GAP = 2,
    parameter int LONG_GAP  = 3
) (
    input  prev_t prev,
    input  xfer_t next,
    output cnt_t  gap
);
    localparam cnt_t SHORT_C = cnt_t'(SHORT_GAP);
    localparam cnt_t LONG_C  = cnt_t'(LONG_GAP);

    always_comb gap = pick_gap(prev, next, SHORT_C, LONG_C);
endmodule

// File: rtl/tat_prev_track.sv
module tat_prev_track
    import tat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  grant,
    input  xfer_t xfer,
    input  turn_t bank_turn,
    input  logic  bank_mode_d,
    output prev_t prev_q,
    output cnt_t  elapsed_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            elapsed_q <= '0;
        end else if (grant) begin
            prev_q.vld    <= 1'b1;
            prev_q.x      <= xfer;
            prev_q.mode_d <= bank_mode_d;
            prev_q.turn   <= bank_turn;
            elapsed_q     <= '0;
        end else if (elapsed_q != '1) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // R10: idle count restarts at each grant
    a_r10_elapsed_restart: assert property (@(posedge clk) disable iff (rst)
        grant |=> (elapsed_q == '0));
    // R11: snapshot of the turnaround count is frozen between grants
    a_r11_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
        !grant |=> $stable(prev_q.turn));
endmodule

// File: rtl/turnaround_sched.sv
module turnaround_sched
    import tat_pkg::*;
#(
    parameter int SHORT_GAP = 2,
    parameter int LONG_GAP  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_bank,
    input  logic [3:0] cfg_turn,
    input  logic [1:0] cfg_mode,
    input  logic [3:0] ext_mode_en,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_bank,
    input  logic       req_write,
    input  logic       req_sync,
    input  logic       req_mux
);
    bank_cfg_t [NUM_BANKS-1:0] cfg_q;
    bank_cfg_t wcfg;
    xfer_t     next_x;
    prev_t     prev_q;
    cnt_t      elapsed_q;
    cnt_t      gap;
    logic      grant;
    logic      sel_mode_d;

    always_comb begin
        wcfg.turn   = cfg_turn;
        wcfg.mode   = amode_e'(cfg_mode);
        next_x.bank = req_bank;
        next_x.wr   = req_write;
        next_x.sy   = req_sync;
        next_x.mx   = req_mux;
        sel_mode_d  = ext_mode_en[req_bank] && (cfg_q[req_bank].mode == MODE_D);
    end

    tat_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wbank (cfg_bank),
        .wcfg  (wcfg),
        .cfg_q (cfg_q)
    );

    tat_gap_sel #(.SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)) u_gap (
        .prev (prev_q),
        .next (next_x),
        .gap  (gap)
    );

    tat_prev_track u_track (
        .clk         (clk),
        .rst         (rst),
        .grant       (grant),
        .xfer        (next_x),
        .bank_turn   (cfg_q[req_bank].turn),
        .bank_mode_d (sel_mode_d),
        .prev_q      (prev_q),
        .elapsed_q   (elapsed_q)
    );

    assign req_ready = !prev_q.vld || (elapsed_q >= gap);
    assign grant     = req_valid && req_ready;

    // R1: nothing recorded yet -> no stall
    a_r1_first_grant: assert property (@(posedge clk) disable iff (rst)
        !prev_q.vld |-> req_ready);
    // R6: a read leaves no turnaround behind
    a_r6_read_free: assert property (@(posedge clk) disable iff (rst)
        (prev_q.vld && !prev_q.x.wr) |-> req_ready);
    // R7: after a synchronous write the next grant is never in the very next cycle
    a_r7_sync_write_min_gap: assert property (@(posedge clk) disable iff (rst)
        (grant && req_sync && req_write) |=> !grant);
endmodule

// File: tb/turnaround_sched_tb.sv
`timescale 1ns/100ps
module turnaround_sched_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_bank = '0;
    logic [3:0] cfg_turn = '0;
    logic [1:0] cfg_mode = '0;
    logic [3:0] ext_mode_en = 4'b0011;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_bank = '0;
    logic req_write = 1'b0;
    logic req_sync = 1'b0;
    logic req_mux = 1'b0;

    always #2 clk = ~clk;

    turnaround_sched u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_turn(cfg_turn), .cfg_mode(cfg_mode), .ext_mode_en(ext_mode_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_write(req_write), .req_sync(req_sync), .req_mux(req_mux)
    );

    typedef struct { int gap; string tag; } exp_t;
    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   last_g = 0;
    bit   done   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: measures idle cycles between grants
    always @(negedge clk) begin
        #1;
        if (!rst && req_valid && req_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected grant: actual grant expected none");
            end else begin
                exp_t e;
                int idle;
                e = exp_q.pop_front();
                idle = cyc - last_g - 1;
                if (idle != e.gap) begin
                    fails++;
                    $display("FAIL %s: actual gap %0d expected %0d", e.tag, idle, e.gap);
                end
            end
            last_g = cyc;
        end
    end

    task automatic cfg_write(input int b, input int t, input int m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 2'(b); cfg_turn = 4'(t); cfg_mode = 2'(m);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: presents a request at a negedge, holds until granted
    task automatic send(input int b, input bit w, input bit s, input bit m,
                        input int exp_gap, input string tag,
                        input bit mid_cfg = 0, input int mid_turn = 0);
        exp_t e;
        e.gap = exp_gap; e.tag = tag;
        exp_q.push_back(e);
        req_bank = 2'(b); req_write = w; req_sync = s; req_mux = m;
        req_valid = 1'b1;
        for (int k = 0; k < 64; k++) begin
            if (mid_cfg && k == 1) begin
                cfg_we = 1'b1; cfg_bank = 2'(b); cfg_turn = 4'(mid_turn); cfg_mode = 2'd0;
            end
            if (mid_cfg && k == 2) cfg_we = 1'b0;
            #0.5;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #0.5;
        checks++;
        if (req_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset ready: actual %0b expected 1", req_ready);
        end
        // bank0: turn 6 mode A; bank1: turn 4 mode D; bank2: turn 5 mode D but ext off
        cfg_write(0, 6, 0);
        cfg_write(1, 4, 3);
        cfg_write(2, 5, 3);
        @(negedge clk);
        last_g = cyc - 1;
        send(0, 0, 0, 0, 0, "R1 first request");
        send(1, 0, 1, 0, 0, "R6 after read");
        send(0, 1, 0, 0, 0, "R6 write after read");
        send(0, 1, 0, 0, 0, "R4 async wr same bank mode A");
        send(0, 0, 0, 0, 6, "R3 async rd after async wr");
        send(1, 1, 0, 0, 0, "R6 write after read b1");
        send(1, 1, 0, 0, 4, "R4 mode D same bank");
        send(0, 1, 0, 1, 4, "R3 other bank");
        send(0, 1, 0, 1, 6, "R4 muxed same bank");
        send(2, 1, 1, 0, 6, "R3 async wr then sync wr");
        send(2, 1, 1, 0, 2, "R5 sync wr same bank");
        send(2, 0, 0, 0, 2, "R7 sync wr then async rd");
        send(2, 1, 1, 0, 0, "R6 sync wr after read");
        send(3, 1, 1, 0, 3, "R8 sync wr other bank");
        send(3, 0, 1, 0, 3, "R9 sync wr then sync rd");
        send(2, 1, 0, 0, 0, "R6 async wr after read");
        send(2, 1, 0, 0, 0, "R12 ext off mode ignored");
        send(3, 1, 0, 0, 5, "R3 turn of previous bank");
        send(3, 0, 0, 0, 15, "R2 reset turnaround");
        send(0, 1, 0, 0, 0, "R6 async wr after read b0");
        send(0, 0, 0, 0, 6, "R11 cfg write during gap", 1, 1);
        send(0, 1, 0, 0, 0, "R6 write after read b0");
        send(0, 0, 0, 0, 1, "R11 new turn applies later");
        send(1, 1, 1, 0, 0, "R6 sync wr after read b1");
        send(1, 1, 0, 0, 2, "R7 sync wr then async wr");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing grants: actual %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule